// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt requests from three secondary groups (a 32-bit USB core group, a DMA group and a GPIO group) and from one-cycle event pulses raised by neighbouring logic. It folds them into a 32-bit top-level pending word and drives one interrupt line. Each group keeps its own pending bits and mask. Software raises pending bits by writing ones to a set address and removes them by writing ones to a clear address. The USB group's pending bits are reduced to two summary bits, one per half. The DMA group is reduced to one summary bit.

The interrupt line is asserted either while something unmasked is pending or while nothing is, depending on a polarity bit in a configuration word. It is held low whenever the power-ready input is low. All registers sit behind a word-addressed bus with a single-cycle write strobe and a combinational read port.

Top module: `irq_tree_top`

## Requirements
- R1: A write to a group's set address (group base + 1) ORs the write data into that group's pending bits. This applies to the USB group (base 0), the DMA group (base 4), the GPIO group (base 8) and the top group (base 12).
- R2: A write to a group's clear address (base + 2) clears every pending bit written as 1 and leaves the others unchanged. A write to a source address (base + 0) has no effect.
- R3: Top-level bit 9 reads 1 exactly while some bit of USB pending[15:0] is pending with its USB mask bit 0. Top-level bit 8 does the same for USB pending[31:16].
- R4: Top-level bit 24 reads 1 exactly while some DMA pending bit is pending with its DMA mask bit 0.
- R5: When configuration bit 17 (address 16) is 1, irqOut is 1 while any top-level bit is pending with its top mask bit 0. When that bit is 0, irqOut is 1 only while no such bit exists. irqOut follows a write on the first clock edge after it.
- R6: irqOut is 0 whenever powerReady is 0.
- R7: After reset every pending word is 0, the top mask (address 15) is 0xFFFFFFFF, the group masks and the configuration word are 0.
- R8: Reading a group's source, set or clear address returns that group's pending bits. The top group returns its stored bits together with the summary bits. Reading base + 3 returns the mask, and address 16 returns the configuration word.
- R9: A 1 on evtPulse[i] sets top-level pending bit i on the next edge. This takes priority over a clear of that bit written in the same cycle.
- R10: Top-level bits 8, 9 and 24 reflect only the summaries. Writes to the top set address and event pulses do not set them. The GPIO group never affects the top level or irqOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W | Word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr |
| evtPulse | input | DATA_W | Direct top-level event pulses |
| powerReady | input | 1 | Enables the interrupt line |
| irqOut | output | 1 | Interrupt line |

## Verification
The hardest case to reach is an event pulse that arrives in the same cycle as a software clear of the same bit. The bench drives evtPulse during the clear write, so that both land on one edge, and then reads the bit back. The summary bits are derived rather than stored, which makes them hard to observe. They are checked by driving the USB halves and the DMA group through set, mask and clear sequences and reading the top word after each step. The bench also writes those bit positions directly and confirms that the writes leave no trace.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int NGRP    = 4;
  localparam int USB_GRP = 0;
  localparam int DMA_GRP = 1;
  localparam int GPIO_GRP = 2;
  localparam int TOP_GRP = 3;
  localparam int TX_BIT  = 9;
  localparam int RX_BIT  = 8;
  localparam int DMA_BIT = 24;
  localparam int POL_BIT = 17;
  localparam int CFG_ADDR = 16;

  typedef struct packed {
    logic [NGRP-1:0] setStb;
    logic [NGRP-1:0] clrStb;
    logic [NGRP-1:0] mskStb;
    logic            cfgStb;
    logic [1:0]      rdGrp;
    logic [1:0]      rdFld;
    logic            rdCfg;
    logic            rdValid;
  } strobe_t;
endpackage

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           strb
);
  localparam int GRP_SPAN = NGRP * 4;

  always_comb begin
    strb = '0;
    if (busAddr == ADDR_W'(CFG_ADDR)) begin
      strb.rdCfg  = 1'b1;
      strb.cfgStb = busWrEn;
    end else if (busAddr < ADDR_W'(GRP_SPAN)) begin
      strb.rdValid = 1'b1;
      strb.rdGrp   = busAddr[3:2];
      strb.rdFld   = busAddr[1:0];
      if (busWrEn) begin
        case (busAddr[1:0])
          2'd1:    strb.setStb[busAddr[3:2]] = 1'b1;
          2'd2:    strb.clrStb[busAddr[3:2]] = 1'b1;
          2'd3:    strb.mskStb[busAddr[3:2]] = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_group_reg.sv
module irq_group_reg #(
  parameter int           W        = 32,
  parameter logic [W-1:0] MASK_RST = '0,
  parameter logic [W-1:0] KEEP     = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic         mskStb,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] evt,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask
);
  logic [W-1:0] setBits;
  logic [W-1:0] clrBits;

  assign setBits = setStb ? wrData : '0;
  assign clrBits = clrStb ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= MASK_RST;
    end else begin
      pend <= ((pend & ~clrBits) | setBits | evt) & KEEP;
      if (mskStb) mask <= wrData;
    end
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (rst)
    setStb |=> ((pend & $past(wrData & KEEP)) == $past(wrData & KEEP)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (clrStb && !setStb && evt == '0) |=> ((pend & $past(wrData)) == '0));

  assert_evt_R9: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend & $past(evt & KEEP)) == $past(evt & KEEP)));
endmodule

// File: rtl/irq_tree_dp.sv
module irq_tree_dp
  import irq_tree_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic              powerReady,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] SUMMARY =
    (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << DMA_BIT);

  logic [DATA_W-1:0] pendArr [NGRP];
  logic [DATA_W-1:0] maskArr [NGRP];
  logic [DATA_W-1:0] evtArr  [NGRP];
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] topView;
  logic [DATA_W-1:0] usbLive;
  logic usbTx, usbRx, dmaDone, anyLive;

  for (genvar g = 0; g < NGRP; g++) begin : gen_grp
    if (g == TOP_GRP) begin : gen_top
      assign evtArr[g] = evtPulse;
      irq_group_reg #(.W(DATA_W), .MASK_RST({DATA_W{1'b1}}), .KEEP(~SUMMARY)) u_reg (
        .clk(clk), .rst(rst), .setStb(strb.setStb[g]), .clrStb(strb.clrStb[g]),
        .mskStb(strb.mskStb[g]), .wrData(wrData), .evt(evtArr[g]),
        .pend(pendArr[g]), .mask(maskArr[g]));
    end else begin : gen_sub
      assign evtArr[g] = '0;
      irq_group_reg #(.W(DATA_W), .MASK_RST('0), .KEEP({DATA_W{1'b1}})) u_reg (
        .clk(clk), .rst(rst), .setStb(strb.setStb[g]), .clrStb(strb.clrStb[g]),
        .mskStb(strb.mskStb[g]), .wrData(wrData), .evt(evtArr[g]),
        .pend(pendArr[g]), .mask(maskArr[g]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfgReg <= '0;
    else if (strb.cfgStb) cfgReg <= wrData;
  end

  assign usbLive = pendArr[USB_GRP] & ~maskArr[USB_GRP];
  assign usbTx   = |usbLive[HALF-1:0];
  assign usbRx   = |usbLive[DATA_W-1:HALF];
  assign dmaDone = |(pendArr[DMA_GRP] & ~maskArr[DMA_GRP]);

  always_comb begin
    topView = pendArr[TOP_GRP];
    topView[TX_BIT]  = usbTx;
    topView[RX_BIT]  = usbRx;
    topView[DMA_BIT] = dmaDone;
  end

  assign anyLive = |(topView & ~maskArr[TOP_GRP]);
  assign irqOut  = powerReady & (cfgReg[POL_BIT] ? anyLive : ~anyLive);

  always_comb begin
    rdData = '0;
    if (strb.rdCfg) begin
      rdData = cfgReg;
    end else if (strb.rdValid) begin
      if (strb.rdFld == 2'd3)             rdData = maskArr[strb.rdGrp];
      else if (strb.rdGrp == 2'(TOP_GRP)) rdData = topView;
      else                                rdData = pendArr[strb.rdGrp];
    end
  end

  assert_usbsum_R3: assert property (@(posedge clk) disable iff (rst)
    ((pendArr[USB_GRP] & ~maskArr[USB_GRP]) == '0) |-> (!topView[TX_BIT] && !topView[RX_BIT]));

  assert_dmasum_R4: assert property (@(posedge clk) disable iff (rst)
    ((pendArr[DMA_GRP] & ~maskArr[DMA_GRP]) == '0) |-> !topView[DMA_BIT]);
endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic              powerReady,
  output logic              irqOut
);
  strobe_t strb;

  irq_tree_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb));

  irq_tree_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(busWrData), .evtPulse(evtPulse),
    .powerReady(powerReady), .rdData(busRdData), .irqOut(irqOut));

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !powerReady |-> !irqOut);
endmodule

// File: tb/sim_irq_tree_top.sv
module sim_irq_tree_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] evtPulse = '0;
  logic        powerReady = 0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  irq_tree_top u0 (.clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .evtPulse(evtPulse),
    .powerReady(powerReady), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrEvt(logic [4:0] a, logic [31:0] d, logic [31:0] e);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1; evtPulse = e;
    @(negedge clk);
    busWrEn = 0; evtPulse = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wrEvt(a, d, '0);
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(15, v); check("R7 top mask", v, 32'hFFFFFFFF);
    rd(12, v); check("R7 top pend", v, 0);
    rd(3, v);  check("R7 usb mask", v, 0);
    rd(16, v); check("R7 cfg", v, 0);
    check("R6 irq gated", irqOut, 0);
    powerReady = 1; #1;
    check("R5 pol0 idle high", irqOut, 1);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(1, 32'h5); wr(1, 32'h10);
    rd(0, v); check("R1 usb set or", v, 32'h15);
    rd(1, v); check("R8 read set addr", v, 32'h15);
    rd(2, v); check("R8 read clr addr", v, 32'h15);
    wr(2, 32'h4);
    rd(0, v); check("R2 clear", v, 32'h11);
    wr(0, 32'hFFFF);
    rd(0, v); check("R2 src write ignored", v, 32'h11);
  endtask

  task automatic t_usbsum();
    logic [31:0] v;
    rd(12, v); check("R3 tx summary", v, 32'h200);
    wr(1, 32'h0001_0000);
    rd(12, v); check("R3 tx+rx summary", v, 32'h300);
    wr(3, 32'h0000_FFFF);
    rd(3, v);  check("R8 usb mask read", v, 32'h0000_FFFF);
    rd(12, v); check("R3 low half masked", v, 32'h100);
    wr(2, 32'hFFFF_FFFF);
    rd(12, v); check("R3 summaries clear", v, 0);
    wr(3, 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(5, 32'h1);
    rd(12, v); check("R4 dma summary", v, 32'h0100_0000);
    wr(7, 32'h1);
    rd(12, v); check("R4 dma masked", v, 0);
    wr(6, 32'h1); wr(7, 0);
    rd(4, v);  check("R4 dma cleared", v, 0);
  endtask

  task automatic t_pol();
    logic [31:0] v;
    wr(13, 32'h1);
    rd(12, v); check("R1 top set", v, 32'h1);
    #1 check("R5 pol0 all masked", irqOut, 1);
    wr(15, 32'hFFFF_FFFE);
    #1 check("R5 pol0 pending", irqOut, 0);
    wr(16, 32'h0002_0000);
    #1 check("R5 pol1 pending", irqOut, 1);
    wr(14, 32'h1);
    #1 check("R5 pol1 idle", irqOut, 0);
    wr(13, 32'h1);
    powerReady = 0; #1;
    check("R6 gated pol1", irqOut, 0);
    powerReady = 1; #1;
    check("R6 ungated pol1", irqOut, 1);
    wr(14, 32'h1);
  endtask

  task automatic t_evt();
    logic [31:0] v;
    @(negedge clk); evtPulse = 32'h4000;
    @(negedge clk); evtPulse = 0;
    rd(12, v); check("R9 event sets", v, 32'h4000);
    wrEvt(14, 32'h4000, 32'h4000);
    rd(12, v); check("R9 event beats clear", v, 32'h4000);
    wr(14, 32'h4000);
    rd(12, v); check("R2 top clear", v, 0);
  endtask

  task automatic t_protect();
    logic [31:0] v;
    wr(13, 32'h0100_0300);
    rd(12, v); check("R10 summary not settable", v, 0);
    wrEvt(0, 0, 32'h0100_0300);
    rd(12, v); check("R10 summary not by event", v, 0);
    wr(15, 0);
    wr(9, 32'hFF);
    rd(8, v);  check("R1 gpio set", v, 32'hFF);
    rd(12, v); check("R10 gpio no top", v, 0);
    #1 check("R10 gpio no irq", irqOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_setclr();
    t_usbsum();
    t_dma();
    t_pol();
    t_evt();
    t_protect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule